// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block holds the 8-bit condition code register of a small accumulator-style CPU and rewrites it after each executed instruction. The instruction class decides which flags move. Each flag then takes its value from the ALU's operands, result, carry-out and overflow lines, from a multiply/divide error line or from a shift-out bit. Classes that must leave the flags alone, such as push, pull, index add, transfer and exchange, map to a hold class.

The two interrupt mask bits and the stop-disable bit are only stored here. The flag logic never writes them. A direct load writes all eight bits at once and is used to restore the register from the stack. The current carry is also driven out as the carry-in for shift and rotate operations, so that multi-word shifts chain through C.

Top module: `cond_flags_unit`

## Requirements
- R1: Bit layout from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C. After reset `ccr_o` reads 0xD0 (S, X and I set).
- R2: When `ccr_ld_i` is high at a clock edge, `ccr_o` takes `ccr_d_i` on all eight bits. This load wins over a flag update in the same cycle.
- R3: S, X and I (bits 7, 6 and 4) change only through a direct load. No flag update of any class alters them.
- R4: With `upd_i` low, or with class 0 (hold: push, pull, index add, transfer), `ccr_o` does not change.
- R5: Class 1 (load/store): N gets result bit 7, Z is set when the result is zero, and V is cleared. H and C keep their values.
- R6: Class 2 (add): H is the carry out of bit 3, computed as a3&b3 | a3&~r3 | b3&~r3. N and Z follow the result, V takes `ovf_i` and C takes `carry_i`.
- R7: Class 3 (subtract/compare): N and Z follow the result, V takes `ovf_i` and C takes `carry_i` as the borrow. H is unchanged.
- R8: Class 4 (logic): N and Z follow the result and V is cleared. H and C are unchanged.
- R9: Class 5 (shift/rotate): C takes `shout_i`, N and Z follow the result, and V is N xor the new C. `shcin_o` always equals the current C bit of `ccr_o`.
- R10: Class 6 (multiply/divide): C takes `mderr_i`. Every other bit is unchanged.
- R11: Class 7 (increment/decrement): N and Z follow the result and V takes `ovf_i`. H and C are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Apply the flag update for `cls_i` this cycle |
| cls_i | input | 3 | Instruction class code (0..7 as in R4–R11) |
| opa_i | input | 8 | ALU operand A |
| opb_i | input | 8 | ALU operand B |
| res_i | input | 8 | ALU result |
| carry_i | input | 1 | ALU carry-out or borrow |
| ovf_i | input | 1 | ALU signed overflow |
| mderr_i | input | 1 | Multiply/divide error indication |
| shout_i | input | 1 | Bit shifted out by a shift or rotate |
| ccr_ld_i | input | 1 | Direct load of the whole register |
| ccr_d_i | input | 8 | Value for the direct load |
| ccr_o | output | 8 | Condition code register |
| shcin_o | output | 1 | Carry-in for shifts and rotates (current C) |

## Verification
Every update and every direct load is registered once, so `ccr_o` shows its effect one clock edge after the inputs are sampled. `shcin_o` follows `ccr_o` in the same cycle. The bench drives its inputs on the falling edge and lets one rising edge pass. It compares `ccr_o` and `shcin_o` on the next falling edge, before any new stimulus, so an unchanged flag is seen at the port before anything else could move it. The bench keeps its own model register and updates it by the rules of each class.

// File: rtl/cond_flags_pkg.sv
package cond_flags_pkg;
  localparam int unsigned CCR_W = 8;

  localparam int unsigned B_C = 0;
  localparam int unsigned B_V = 1;
  localparam int unsigned B_Z = 2;
  localparam int unsigned B_N = 3;
  localparam int unsigned B_I = 4;
  localparam int unsigned B_H = 5;
  localparam int unsigned B_X = 6;
  localparam int unsigned B_S = 7;

  localparam logic [CCR_W-1:0] CTRL_MASK = (1 << B_S) | (1 << B_X) | (1 << B_I);
  localparam logic [CCR_W-1:0] CCR_RST   = CTRL_MASK;

  typedef enum logic [2:0] {
    CLS_HOLD   = 3'd0,
    CLS_LDST   = 3'd1,
    CLS_ADD    = 3'd2,
    CLS_SUB    = 3'd3,
    CLS_LOGIC  = 3'd4,
    CLS_SHIFT  = 3'd5,
    CLS_MULDIV = 3'd6,
    CLS_INCDEC = 3'd7
  } flag_cls_e;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import cond_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  flag_cls_e          cls_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [DATA_W-1:0]  res_i,
  input  logic               carry_i,
  input  logic               ovf_i,
  input  logic               mderr_i,
  input  logic               shout_i,
  output logic [CCR_W-1:0]   wen_o,
  output logic [CCR_W-1:0]   val_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic n_w, z_w, h_w;

  assign n_w = res_i[MSB];
  assign z_w = ~|res_i;
  // half carry out of bit 3, recovered from operands and sum
  assign h_w = (opa_i[3] & opb_i[3]) | (opa_i[3] & ~res_i[3]) | (opb_i[3] & ~res_i[3]);

  always_comb begin
    wen_o = '0;
    val_o = '0;
    unique case (cls_i)
      CLS_LDST, CLS_LOGIC: begin
        wen_o[B_N] = 1'b1; wen_o[B_Z] = 1'b1; wen_o[B_V] = 1'b1;
        val_o[B_N] = n_w;  val_o[B_Z] = z_w;  val_o[B_V] = 1'b0;
      end
      CLS_ADD: begin
        wen_o[B_H] = 1'b1; wen_o[B_N] = 1'b1; wen_o[B_Z] = 1'b1;
        wen_o[B_V] = 1'b1; wen_o[B_C] = 1'b1;
        val_o[B_H] = h_w;  val_o[B_N] = n_w;  val_o[B_Z] = z_w;
        val_o[B_V] = ovf_i; val_o[B_C] = carry_i;
      end
      CLS_SUB: begin
        wen_o[B_N] = 1'b1; wen_o[B_Z] = 1'b1; wen_o[B_V] = 1'b1; wen_o[B_C] = 1'b1;
        val_o[B_N] = n_w;  val_o[B_Z] = z_w;  val_o[B_V] = ovf_i; val_o[B_C] = carry_i;
      end
      CLS_SHIFT: begin
        wen_o[B_N] = 1'b1; wen_o[B_Z] = 1'b1; wen_o[B_V] = 1'b1; wen_o[B_C] = 1'b1;
        val_o[B_N] = n_w;  val_o[B_Z] = z_w;
        val_o[B_V] = n_w ^ shout_i; val_o[B_C] = shout_i;
      end
      CLS_MULDIV: begin
        wen_o[B_C] = 1'b1;
        val_o[B_C] = mderr_i;
      end
      CLS_INCDEC: begin
        wen_o[B_N] = 1'b1; wen_o[B_Z] = 1'b1; wen_o[B_V] = 1'b1;
        val_o[B_N] = n_w;  val_o[B_Z] = z_w;  val_o[B_V] = ovf_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccr_store.sv
module ccr_store
  import cond_flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [CCR_W-1:0]  wen_i,
  input  logic [CCR_W-1:0]  val_i,
  input  logic              ld_i,
  input  logic [CCR_W-1:0]  ld_d_i,
  output logic [CCR_W-1:0]  q_o
);
  for (genvar b = 0; b < CCR_W; b++) begin : g_bit
    if (CTRL_MASK[b]) begin : g_ctrl
      // control bits: direct load only
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_o[b] <= CCR_RST[b];
        else if (ld_i) q_o[b] <= ld_d_i[b];
      end
    end else begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  q_o[b] <= CCR_RST[b];
        else if (ld_i)                q_o[b] <= ld_d_i[b];
        else if (upd_i && wen_i[b])   q_o[b] <= val_i[b];
      end
    end
  end

  AST_LD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(ld_d_i)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (q_o & CTRL_MASK) == $past(q_o & CTRL_MASK)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !upd_i) |=> $stable(q_o)); // R4
endmodule

// File: rtl/cond_flags_unit.sv
module cond_flags_unit
  import cond_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        cls_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              mderr_i,
  input  logic              shout_i,
  input  logic              ccr_ld_i,
  input  logic [7:0]        ccr_d_i,
  output logic [7:0]        ccr_o,
  output logic              shcin_o
);
  flag_cls_e         cls_w;
  logic [CCR_W-1:0]  wen_w, val_w, ccr_q;

  assign cls_w = flag_cls_e'(cls_i);

  flag_calc #(.DATA_W(DATA_W)) calc_i (
    .cls_i   (cls_w),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .res_i   (res_i),
    .carry_i (carry_i),
    .ovf_i   (ovf_i),
    .mderr_i (mderr_i),
    .shout_i (shout_i),
    .wen_o   (wen_w),
    .val_o   (val_w)
  );

  ccr_store store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .wen_i  (wen_w),
    .val_i  (val_w),
    .ld_i   (ccr_ld_i),
    .ld_d_i (ccr_d_i),
    .q_o    (ccr_q)
  );

  assign ccr_o   = ccr_q;
  assign shcin_o = ccr_q[B_C];

  AST_HOLD_CLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd0) |=> $stable(ccr_o)); // R4
  AST_LDST_VCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd1) |=> !ccr_o[B_V]); // R5
  AST_ADD_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd2) |=> ccr_o[B_C] == $past(carry_i)); // R6
  AST_SUB_H_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd3) |=> $stable(ccr_o[B_H])); // R7
  AST_SHIFT_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd5) |=> ccr_o[B_C] == $past(shout_i)); // R9
  AST_MULDIV_ONLY_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd6) |=> (ccr_o[7:1] == $past(ccr_o[7:1]))); // R10
  AST_INCDEC_C_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ccr_ld_i && cls_i == 3'd7) |=> $stable(ccr_o[B_C])); // R11
endmodule

// File: tb/cond_flags_unit_tb.sv
module cond_flags_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       upd_i = 1'b0;
  logic [2:0] cls_i = '0;
  logic [7:0] opa_i = '0, opb_i = '0, res_i = '0;
  logic       carry_i = 1'b0, ovf_i = 1'b0, mderr_i = 1'b0, shout_i = 1'b0;
  logic       ccr_ld_i = 1'b0;
  logic [7:0] ccr_d_i = '0;
  logic [7:0] ccr_o;
  logic       shcin_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model;

  always #10 clk_i = ~clk_i;

  cond_flags_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .cls_i(cls_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .carry_i(carry_i),
    .ovf_i(ovf_i), .mderr_i(mderr_i), .shout_i(shout_i),
    .ccr_ld_i(ccr_ld_i), .ccr_d_i(ccr_d_i), .ccr_o(ccr_o), .shcin_o(shcin_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // bit order S X H I N Z V C
  task automatic step(input logic upd, input logic [2:0] cls, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] r, input logic c,
                      input logic v, input logic e, input logic s,
                      input logic ld, input logic [7:0] d);
    upd_i = upd; cls_i = cls; opa_i = a; opb_i = b; res_i = r;
    carry_i = c; ovf_i = v; mderr_i = e; shout_i = s; ccr_ld_i = ld; ccr_d_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    upd_i = 1'b0; ccr_ld_i = 1'b0;
  endtask

  task automatic nz(input logic [7:0] r);
    model[3] = r[7];
    model[2] = (r == 8'h00);
  endtask

  task automatic do_load(input logic [7:0] d, input string req);
    step(1'b0, 3'd0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, d);
    model = d;
    check(req, ccr_o, model);
  endtask

  task automatic t_reset;
    check("R1 reset", ccr_o, 8'hD0);
    check("R9 shcin after reset", {7'd0, shcin_o}, 8'h00);
    model = 8'hD0;
  endtask

  task automatic t_direct_load;
    do_load(8'h2B, "R2 load");
    do_load(8'hFF, "R2 load all ones");
    // load beats an add that would clear flags
    step(1'b1, 3'd2, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h15);
    model = 8'h15;
    check("R2 load priority", ccr_o, model);
  endtask

  task automatic t_hold;
    do_load(8'h6F, "R2 setup");
    step(1'b1, 3'd0, 8'h12, 8'h34, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R4 hold class", ccr_o, model);
    step(1'b0, 3'd2, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R4 no strobe", ccr_o, model);
  endtask

  task automatic t_ldst;
    do_load(8'h23, "R2 setup");  // H=1, V=1, C=1
    step(1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h00); model[1] = 1'b0;
    check("R5 ldst zero", ccr_o, model);
    step(1'b1, 3'd1, 8'h00, 8'h00, 8'h9C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h9C); model[1] = 1'b0;
    check("R5 ldst negative", ccr_o, model);
  endtask

  task automatic t_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] sum;
    logic       v;
    sum = {1'b0, a} + {1'b0, b};
    v = (a[7] == b[7]) && (sum[7] != a[7]);
    step(1'b1, 3'd2, a, b, sum[7:0], sum[8], v, 1'b0, 1'b0, 1'b0, 8'h00);
    model[5] = (({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15);
    nz(sum[7:0]); model[1] = v; model[0] = sum[8];
    check("R6 add", ccr_o, model);
  endtask

  task automatic t_sub;
    do_load(8'h20, "R2 setup");  // H set, must stay
    step(1'b1, 3'd3, 8'h10, 8'h20, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'hF0); model[1] = 1'b0; model[0] = 1'b1;
    check("R7 sub borrow", ccr_o, model);
    step(1'b1, 3'd3, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h7F); model[1] = 1'b1; model[0] = 1'b0;
    check("R7 sub overflow", ccr_o, model);
  endtask

  task automatic t_logic;
    do_load(8'h03, "R2 setup");
    step(1'b1, 3'd4, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h00); model[1] = 1'b0;
    check("R8 logic", ccr_o, model);
  endtask

  task automatic t_shift;
    do_load(8'h00, "R2 setup");
    step(1'b1, 3'd5, 8'h81, 8'h00, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    nz(8'h02); model[0] = 1'b1; model[1] = model[3] ^ model[0];
    check("R9 shift out one", ccr_o, model);
    check("R9 shcin follows C", {7'd0, shcin_o}, 8'h01);
    step(1'b1, 3'd5, 8'h40, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h80); model[0] = 1'b0; model[1] = model[3] ^ model[0];
    check("R9 shift negative", ccr_o, model);
    check("R9 shcin clear", {7'd0, shcin_o}, 8'h00);
  endtask

  task automatic t_muldiv;
    do_load(8'h2E, "R2 setup");
    step(1'b1, 3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    model[0] = 1'b1;
    check("R10 muldiv error", ccr_o, model);
    step(1'b1, 3'd6, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    model[0] = 1'b0;
    check("R10 muldiv ok", ccr_o, model);
  endtask

  task automatic t_incdec;
    do_load(8'h21, "R2 setup");
    step(1'b1, 3'd7, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    nz(8'h80); model[1] = 1'b1;
    check("R11 inc overflow", ccr_o, model);
  endtask

  task automatic t_ctrl_bits;
    do_load(8'h00, "R2 setup");
    t_add(8'hFF, 8'hFF);
    check("R3 ctrl clear kept", ccr_o & 8'hD0, 8'h00);
    do_load(8'hD0, "R2 setup");
    t_add(8'h08, 8'h08);
    step(1'b1, 3'd5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    nz(8'h00); model[0] = 1'b1; model[1] = model[3] ^ model[0];
    check("R3 ctrl set kept", ccr_o & 8'hD0, 8'hD0);
  endtask

  initial begin
    fork
      begin
        #5;
        @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 after release", ccr_o, 8'hD0);
        t_direct_load();
        t_hold();
        t_ldst();
        do_load(8'h00, "R2 setup");
        t_add(8'h0F, 8'h01);
        t_add(8'h80, 8'h80);
        t_add(8'h50, 8'h30);
        t_sub();
        t_logic();
        t_shift();
        t_muldiv();
        t_incdec();
        t_ctrl_bits();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule